// File: doc/BRIEF.md
# Periodic Interrupt Interval Timer

This block measures out fixed time intervals for a host. A prescaler divides the system clock into a slow tick of about 100 µs (2696 cycles of a 27 MHz clock by default). An 8-bit down counter runs off that tick, so one control write sets an interval of 1 to 255 ticks, roughly 100 µs to 25.5 ms. When the interval has run out, the block gives a one-cycle expiry strobe that neighbouring blocks can use to capture data. It also sets a sticky status flag, which drives the interrupt line while the interrupt enable is high.

A single 16-bit control word holds both the setup and the command. The interval count is in bits [15:8], the mode is in bit 1 (0 = single-shot, 1 = periodic), and a start request is in bit 0. The start request only has an effect in single-shot mode. A periodic setup starts running as soon as it is written. Any write reloads the counter and restarts the prescaler, so a rewrite while the timer is running begins a fresh interval. The counter is controlled by a two-state machine. In IDLE it waits for a write. The transition IDLE→RUN is taken on a write with a nonzero count that is either periodic or has the start bit set. Any other write goes to IDLE. In RUN the counter drops by one on each tick. On the tick that takes it past 1 it fires. It then either stays in RUN and reloads (periodic: RUN→RUN) or returns to IDLE (single-shot: RUN→IDLE).

Top module: `intv_timer`

## Requirements
- R1: After reset, the expiry strobe, status flag and interrupt line are all 0. No expiry happens until the control word is written.
- R2: A write of count N (bits [15:8], N ≥ 1) with bit 1 = 0 and bit 0 = 1 gives exactly one expiry strobe, N·TICK_DIV cycles after the write edge. No further strobes follow.
- R3: A write of count N with bit 1 = 1 gives expiry strobes N·TICK_DIV cycles after the write, and then every N·TICK_DIV cycles until the next write.
- R4: Bit 0 has no effect when bit 1 = 1. A write with bit 1 = 0 and bit 0 = 0 stops the timer, and no strobe follows.
- R5: A count of 0 never produces an expiry, whatever the mode or start bit.
- R6: The expiry strobe is high for exactly one clock cycle per expiry.
- R7: The status flag goes high on the clock edge after the strobe. It stays high until stat_clr is 1 at an edge. If a set and a clear fall on the same edge, the set wins.
- R8: irq equals status flag AND irq_en at all times.
- R9: A control write while the timer is running discards the remaining count, and the new interval is measured from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word: [15:8] count, [1] periodic, [0] start |
| stat_clr | input | 1 | Clear for the status flag (write-1-to-clear) |
| irq_en | input | 1 | Interrupt enable |
| stat_o | output | 1 | Sticky expiry status flag |
| irq | output | 1 | Interrupt request |
| expire_o | output | 1 | One-cycle expiry strobe |

## Verification
Random counts, modes and start-bit values are written. The cycle distance from each write to the first strobe tells a correct N·TICK_DIV interval apart from an off-by-one in the prescaler or the counter. In periodic runs, the distance between one strobe and the next separates a proper reload from a stall or a double count. In single-shot runs, a long quiet window afterwards catches a missing stop. Directed cases cover a zero count, a periodic write with and without bit 0, a single-shot write without bit 0, and a rewrite in the middle of an interval. Further directed cases cover a clear that lands on the same edge as a new set, and irq with the enable off and on.

// File: rtl/intv_timer_pkg.sv
package intv_timer_pkg;
    localparam int CTL_W     = 16;
    localparam int LOAD_LSB  = 8;
    localparam int AUTO_BIT  = 1;
    localparam int START_BIT = 0;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/intv_prescale.sv
module intv_prescale #(
    parameter int TICK_DIV = 2696
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] pcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt <= '0;
        else if (restart || pcnt == LAST)
            pcnt <= '0;
        else
            pcnt <= pcnt + PW'(1);
    end

    assign tick = (pcnt == LAST);

    // R9
    restart_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);
endmodule

// File: rtl/intv_count_fsm.sv
module intv_count_fsm
    import intv_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_load,
    input  logic             wr_auto,
    input  logic             wr_start,
    input  logic             tick,
    output logic             expire_o
);
    tmr_state_e       st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [CNT_W-1:0] load_q;
    logic             auto_q;
    logic             fire;
    logic             go;

    assign go = wr_en && (wr_load != '0) && (wr_auto || wr_start);

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        fire  = 1'b0;
        if (wr_en) begin
            st_n  = go ? ST_RUN : ST_IDLE;
            cnt_n = wr_load;
        end else begin
            unique case (st)
                ST_IDLE: st_n = ST_IDLE;
                ST_RUN: begin
                    if (tick) begin
                        if (cnt == CNT_W'(1)) begin
                            fire = 1'b1;
                            if (auto_q) begin
                                cnt_n = load_q;
                            end else begin
                                st_n = ST_IDLE;
                            end
                        end else begin
                            cnt_n = cnt - CNT_W'(1);
                        end
                    end
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            load_q <= '0;
            auto_q <= 1'b0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            if (wr_en) begin
                load_q <= wr_load;
                auto_q <= wr_auto;
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            expire_o <= 1'b0;
        else
            expire_o <= fire;
    end

    // R6
    one_cycle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !expire_o);

    // R2
    fire_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> $past(st == ST_RUN));

    // R2
    single_shot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !auto_q) |=> (st == ST_IDLE));

    // R5
    zero_load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_load == '0) |=> (st == ST_IDLE));
endmodule

// File: rtl/intv_status.sv
module intv_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic stat_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stat_q <= 1'b0;
        else if (set_i)
            stat_q <= 1'b1;
        else if (clr_i)
            stat_q <= 1'b0;
    end

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> stat_q);

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && !clr_i) |=> stat_q);
endmodule

// File: rtl/intv_timer.sv
module intv_timer
    import intv_timer_pkg::*;
#(
    parameter int TICK_DIV = 2696,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             stat_clr,
    input  logic             irq_en,
    output logic             stat_o,
    output logic             irq,
    output logic             expire_o
);
    logic tick;

    intv_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ctl_we),
        .tick    (tick)
    );

    intv_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctl_we),
        .wr_load  (ctl_wdata[LOAD_LSB +: CNT_W]),
        .wr_auto  (ctl_wdata[AUTO_BIT]),
        .wr_start (ctl_wdata[START_BIT]),
        .tick     (tick),
        .expire_o (expire_o)
    );

    intv_status u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (expire_o),
        .clr_i  (stat_clr),
        .stat_q (stat_o)
    );

    assign irq = stat_o & irq_en;

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!expire_o && !stat_o));
endmodule

// File: tb/tb_intv_timer.sv
module tb_intv_timer;
    localparam int DIV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic        stat_clr = 1'b0;
    logic        irq_en = 1'b0;
    logic        stat_o, irq, expire_o;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    logic prev_exp = 1'b0;

    always #4 clk = ~clk;

    intv_timer #(.TICK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .stat_clr(stat_clr), .irq_en(irq_en),
        .stat_o(stat_o), .irq(irq), .expire_o(expire_o)
    );

    function automatic int exp_interval(input int n);
        return n * DIV;
    endfunction

    function automatic logic [15:0] ctl_word(input int n, input bit auto_m, input bit st);
        return {8'(n), 6'd0, auto_m, st};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // pulse counter and width monitor (R6), sampled at negedge
    always @(negedge clk) begin
        if (rst_n) begin
            if (expire_o) pulses++;
            if (expire_o && prev_exp) begin
                checks++; errors++;
                $display("FAIL R6: actual width 2 expected 1");
            end
            // R8 continuous relation
            if (irq !== (stat_o & irq_en)) begin
                checks++; errors++;
                $display("FAIL R8: actual %0d expected %0d", irq, stat_o & irq_en);
            end
        end
        prev_exp = expire_o;
    end

    task automatic write_ctl(input logic [15:0] w);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = w;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wait_pulse(input int limit, output int k);
        k = 0;
        while (k < limit) begin
            @(negedge clk);
            k++;
            if (expire_o) break;
        end
    endtask

    task automatic clear_status();
        @(negedge clk);
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int k, k2, p0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(expire_o == 0 && stat_o == 0 && irq == 0, "R1", {expire_o, stat_o, irq}, 0);
        repeat (6 * DIV) @(negedge clk);
        chk(pulses == 0, "R1", pulses, 0);

        // random trials, R2 and R3 (with R4 random bit0 in periodic mode)
        for (int t = 0; t < 24; t++) begin
            int n;
            bit am, b0;
            n  = $urandom_range(1, 6);
            am = 1'($urandom_range(0, 1));
            b0 = am ? 1'($urandom_range(0, 1)) : 1'b1;
            write_ctl(ctl_word(n, am, b0));
            wait_pulse(exp_interval(n) + 20, k);
            chk(k == exp_interval(n), am ? "R3" : "R2", k, exp_interval(n));
            @(negedge clk);
            chk(stat_o == 1'b1, "R7", stat_o, 1);
            if (am) begin
                wait_pulse(exp_interval(n) + 20, k2);
                chk(k2 + 1 == exp_interval(n), "R3", k2 + 1, exp_interval(n));
                write_ctl(16'h0000);
            end else begin
                p0 = pulses;
                repeat (2 * exp_interval(n) + 5) @(negedge clk);
                chk(pulses == p0, "R2", pulses - p0, 0);
            end
            clear_status();
            chk(stat_o == 1'b0, "R7", stat_o, 0);
        end

        // R4: periodic with bit0=0 and bit0=1 give same interval
        write_ctl(ctl_word(3, 1'b1, 1'b0));
        wait_pulse(100, k);
        write_ctl(ctl_word(3, 1'b1, 1'b1));
        wait_pulse(100, k2);
        chk(k == exp_interval(3) && k2 == exp_interval(3), "R4", k2, k);
        // R4: single-shot without start bit stops the timer
        write_ctl(ctl_word(3, 1'b0, 1'b0));
        p0 = pulses;
        repeat (8 * DIV) @(negedge clk);
        chk(pulses == p0, "R4", pulses - p0, 0);
        clear_status();

        // R5: zero count never fires
        write_ctl(ctl_word(0, 1'b0, 1'b1));
        repeat (4 * DIV) @(negedge clk);
        write_ctl(ctl_word(0, 1'b1, 1'b1));
        repeat (4 * DIV) @(negedge clk);
        chk(pulses == p0 && stat_o == 0, "R5", pulses - p0, 0);

        // R9: rewrite mid-interval restarts from the new write
        write_ctl(ctl_word(4, 1'b1, 1'b0));
        repeat (DIV + 3) @(negedge clk);
        write_ctl(ctl_word(2, 1'b0, 1'b1));
        wait_pulse(100, k);
        chk(k == exp_interval(2), "R9", k, exp_interval(2));

        // R7: set and clear on the same edge, set wins
        clear_status();
        write_ctl(ctl_word(1, 1'b0, 1'b1));
        wait_pulse(100, k);
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
        chk(stat_o == 1'b1, "R7", stat_o, 1);

        // R8: irq gated by enable
        irq_en = 1'b0;
        @(negedge clk);
        chk(irq == 1'b0, "R8", irq, 0);
        irq_en = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R8", irq, 1);
        clear_status();
        chk(irq == 1'b0, "R8", irq, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule